// File: doc/BRIEF.md
# Halt and Wake Controller

This block parks a processor core in a halted state when the core executes a halt request and lets it run again when a qualifying wake event arrives. When the core enters halt, the block raises a one-cycle halt bus-cycle indication. The other logic on the chip can use that indication for a panel light, a diagnostic interrupt or a watchdog.

The block separates wake events from non-wake events. Wake events are a maskable interrupt with its enable set, a non-maskable interrupt, a system-management interrupt, a debug exception, a bus-init request, an init request and reset. A non-wake event that arrives while the core is halted, or while the wake is being serviced, is not lost. It is collected in a pending vector and handed on only after the service logic acknowledges the wake. When several wake events arrive together, a fixed priority picks the single cause that is reported.

The interrupt controller, the state save for system-management mode and the actual clock stopping are outside this block.

Top module: `hwc_halt_ctl`

## Requirements
- R1: While halted, any wake event makes `halted` low at the next clock edge. In that same cycle `wake_valid` is high for exactly one cycle.
- R2: A `halt_req` seen while running makes `halted` high at the next edge. `halt_cycle` is high only in that first halted cycle.
- R3: `nmi` and `smi` wake the core whatever the value of `irq_en`.
- R4: `irq` with `irq_en` low does not wake the core, and `halted` stays high.
- R5: While halted, and in the service phase (between wake and `wake_ack`), `evt_out` is all zero. Every `evt_in` bit seen in those cycles is OR-collected as pending.
- R6: In the cycle after the cycle in which `wake_ack` is high during service, `evt_out` equals the collected pending bits OR the current `evt_in`. The pending bits are then cleared. A `wake_ack` outside service has no effect.
- R7: `wake_cause` is loaded when the core wakes and holds until the next wake. Codes by priority: init=1, bus_init=2, smi=3, nmi=4, dbg_exc=5, irq with irq_en=6.
- R8: Asserting `rst_n` low, with no clock edge needed, returns the block to running. `halted`, `halt_cycle`, `wake_valid`, `wake_cause` and the pending bits all become zero.
- R9: While running, `evt_out` equals `evt_in` in the same cycle.
- R10: `halt_req` while halted, in service, or in the release cycle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; counts as a wake event |
| halt_req | input | 1 | Core executes a halt |
| irq | input | 1 | Maskable interrupt request |
| irq_en | input | 1 | Interrupt-enable flag |
| nmi | input | 1 | Non-maskable interrupt |
| smi | input | 1 | System-management interrupt |
| dbg_exc | input | 1 | Debug exception |
| bus_init | input | 1 | Bus initialisation request |
| init | input | 1 | Init request |
| evt_in | input | NEVT | Non-wake events |
| wake_ack | input | 1 | Wake has been serviced |
| halted | output | 1 | Core is halted |
| halt_cycle | output | 1 | One-cycle halt bus-cycle indication |
| wake_valid | output | 1 | One-cycle pulse on leaving halt |
| wake_cause | output | 3 | Code of the wake event selected by priority |
| evt_out | output | NEVT | Non-wake events to the core |

## Verification
The hardest situation to reach from the ports is a release that must carry bits collected over several earlier cycles: some arrive while halted, some during service. Those bits must then be merged with a fresh event in the release cycle itself. The stimulus reaches this with directed sequences. The bench raises different `evt_in` bits in separate halted and service cycles, and it holds a masked interrupt on the whole time so the core does not wake early. Then it acknowledges, and drives a new bit in the following cycle. A long random phase follows. It mixes events that arrive together, acknowledges that arrive outside service, and an asynchronous reset applied while bits are pending.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  localparam int NSRC = 6;
  localparam int CW   = 3;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_SVC  = 2'd2,
    ST_REL  = 2'd3
  } hwc_state_e;

  // Grant bit i (priority order, bit 0 highest) maps to cause code i+1.
  function automatic logic [CW-1:0] code_of(input logic [NSRC-1:0] g);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < NSRC; i++)
      if (g[i]) c = CW'(i + 1);
    return c;
  endfunction
endpackage

// File: rtl/hwc_wake_arb.sv
module hwc_wake_arb
  import hwc_pkg::*;
(
  input  logic [NSRC-1:0] req,
  output logic [NSRC-1:0] grant,
  output logic [CW-1:0]   cause,
  output logic            any
);
  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign cause = code_of(grant);
  assign any   = |req;
endmodule

// File: rtl/hwc_defer.sv
module hwc_defer #(
  parameter int NEVT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            clear,
  input  logic [NEVT-1:0] evt_in,
  output logic [NEVT-1:0] pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (clear)   pend_q <= '0;
    else if (capture) pend_q <= pend_q | evt_in;
  end
endmodule

// File: rtl/hwc_halt_ctl.sv
module hwc_halt_ctl
  import hwc_pkg::*;
#(
  parameter int NEVT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_req,
  input  logic            irq,
  input  logic            irq_en,
  input  logic            nmi,
  input  logic            smi,
  input  logic            dbg_exc,
  input  logic            bus_init,
  input  logic            init,
  input  logic [NEVT-1:0] evt_in,
  input  logic            wake_ack,
  output logic            halted,
  output logic            halt_cycle,
  output logic            wake_valid,
  output logic [CW-1:0]   wake_cause,
  output logic [NEVT-1:0] evt_out
);
  hwc_state_e      st_q, st_d;
  logic [NSRC-1:0] wake_src, wake_grant;
  logic [CW-1:0]   arb_cause;
  logic            wake_any, enter_halt, wake_take, hc_q, wv_q;
  logic [CW-1:0]   cause_q;
  logic [NEVT-1:0] pend_q;

  // Priority order: bit 0 highest.
  assign wake_src = {irq & irq_en, dbg_exc, nmi, smi, bus_init, init};

  hwc_wake_arb u_arb (
    .req(wake_src), .grant(wake_grant), .cause(arb_cause), .any(wake_any)
  );

  hwc_defer #(.NEVT(NEVT)) u_defer (
    .clk(clk), .rst_n(rst_n),
    .capture(st_q == ST_HALT || st_q == ST_SVC),
    .clear(st_q == ST_REL),
    .evt_in(evt_in), .pend_q(pend_q)
  );

  assign enter_halt = (st_q == ST_RUN) && halt_req;
  assign wake_take  = (st_q == ST_HALT) && wake_any;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (halt_req) st_d = ST_HALT;
      ST_HALT: if (wake_any) st_d = ST_SVC;
      ST_SVC:  if (wake_ack) st_d = ST_REL;
      ST_REL:  st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      hc_q    <= 1'b0;
      wv_q    <= 1'b0;
      cause_q <= '0;
    end else begin
      st_q <= st_d;
      hc_q <= enter_halt;
      wv_q <= wake_take;
      if (wake_take) cause_q <= arb_cause;
    end
  end

  assign halted     = (st_q == ST_HALT);
  assign halt_cycle = hc_q;
  assign wake_valid = wv_q;
  assign wake_cause = cause_q;

  always_comb begin
    unique case (st_q)
      ST_RUN:  evt_out = evt_in;
      ST_REL:  evt_out = pend_q | evt_in;
      default: evt_out = '0;
    endcase
  end

  p_wake_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && wake_any) |=> (!halted && wake_valid));
  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && halt_req) |=> (halted && halt_cycle));
  p_hc_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halt_cycle |=> !halt_cycle);
  p_nmi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && (nmi || smi) && !irq_en) |=> !halted);
  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wake_any) |=> halted);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT || st_q == ST_SVC) |-> (evt_out == '0));
  p_rel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SVC && wake_ack) |=> (st_q == ST_REL));
  p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && init) |=> (wake_cause == CW'(1)));
  p_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> (wake_cause != '0));
  p_ign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SVC && !wake_ack) |=> (st_q == ST_SVC && !halt_cycle));
endmodule

// File: tb/tb_hwc_halt_ctl.sv
module tb_hwc_halt_ctl;
  localparam int NEVT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, irq = 0, irq_en = 0, nmi = 0, smi = 0;
  logic dbg_exc = 0, bus_init = 0, init = 0, wake_ack = 0;
  logic [NEVT-1:0] evt_in = '0;
  logic halted, halt_cycle, wake_valid;
  logic [2:0] wake_cause;
  logic [NEVT-1:0] evt_out;

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model: 0 run, 1 halted, 2 service, 3 release
  int m_phase = 0;
  bit m_hc = 0, m_wv = 0;
  int m_cause = 0;
  logic [NEVT-1:0] m_pend = '0;

  always #5 clk = ~clk;

  hwc_halt_ctl #(.NEVT(NEVT)) dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .irq(irq), .irq_en(irq_en),
    .nmi(nmi), .smi(smi), .dbg_exc(dbg_exc), .bus_init(bus_init), .init(init),
    .evt_in(evt_in), .wake_ack(wake_ack), .halted(halted),
    .halt_cycle(halt_cycle), .wake_valid(wake_valid), .wake_cause(wake_cause),
    .evt_out(evt_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pick_cause();
    if (init)            return 1;
    if (bus_init)        return 2;
    if (smi)             return 3;
    if (nmi)             return 4;
    if (dbg_exc)         return 5;
    return 6;
  endfunction

  // Per-cycle comparison and model advance, 3 ns after the falling edge.
  always begin
    @(negedge clk);
    #3;
    if (!rst_n) begin
      m_phase = 0; m_hc = 0; m_wv = 0; m_cause = 0; m_pend = '0;
      chk(!halted && !halt_cycle && !wake_valid && wake_cause == 0,
          "R8 reset outputs", {halted, halt_cycle, wake_valid, wake_cause}, 0);
    end else begin
      logic [NEVT-1:0] exp_evt;
      bit wake;
      exp_evt = (m_phase == 0) ? evt_in : (m_phase == 3) ? (m_pend | evt_in) : '0;
      chk(halted == (m_phase == 1), "R1 halted", halted, m_phase == 1);
      chk(halt_cycle == m_hc, "R2 halt_cycle", halt_cycle, m_hc);
      chk(wake_valid == m_wv, "R1 wake_valid", wake_valid, m_wv);
      chk(wake_cause == m_cause[2:0], "R7 wake_cause", wake_cause, m_cause);
      chk(evt_out == exp_evt,
          (m_phase == 0) ? "R9 evt_out" : (m_phase == 3) ? "R6 evt_out" : "R5 evt_out",
          evt_out, exp_evt);
      wake = (irq && irq_en) || dbg_exc || nmi || smi || bus_init || init;
      m_hc = 0; m_wv = 0;
      case (m_phase)
        0: if (halt_req) begin m_phase = 1; m_hc = 1; end
        1: begin
             m_pend = m_pend | evt_in;
             if (wake) begin m_cause = pick_cause(); m_wv = 1; m_phase = 2; end
           end
        2: begin m_pend = m_pend | evt_in; if (wake_ack) m_phase = 3; end
        default: begin m_pend = '0; m_phase = 0; end
      endcase
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr();
    halt_req = 0; irq = 0; irq_en = 0; nmi = 0; smi = 0;
    dbg_exc = 0; bus_init = 0; init = 0; wake_ack = 0; evt_in = '0;
  endtask

  task automatic do_halt();
    clr(); halt_req = 1; tick(); halt_req = 0;
    #1 chk(halted == 1'b1, "R2 entered halt", halted, 1);
  endtask

  task automatic do_ack();
    clr(); wake_ack = 1; tick(); wake_ack = 0; tick();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clr();
    tick(2);
    rst_n = 1;
    tick();
    // R9 passthrough while running
    evt_in = 4'h5; tick(2); evt_in = '0;
    // R4: masked interrupt held, R5 events collected
    do_halt();
    irq = 1; irq_en = 0; evt_in = 4'h1; tick();
    evt_in = 4'h4; tick(); evt_in = '0; tick();
    #1 chk(halted == 1'b1, "R4 masked irq keeps halt", halted, 1);
    // R10: halt_req while halted ignored
    halt_req = 1; tick(); halt_req = 0;
    #1 chk(halt_cycle == 1'b0, "R10 no second halt pulse", halt_cycle, 0);
    // R3: nmi wakes with irq_en low
    nmi = 1; tick(); nmi = 0; irq = 0;
    #1 chk(halted == 1'b0 && wake_cause == 3'd4, "R3 nmi wake", wake_cause, 4);
    // R5 during service, R10 halt_req ignored in service
    evt_in = 4'h8; halt_req = 1; tick(); evt_in = '0; halt_req = 0;
    #1 chk(halted == 1'b0, "R10 halt_req in service", halted, 0);
    // R6 release merged with fresh event
    wake_ack = 1; tick(); wake_ack = 0; evt_in = 4'h2;
    #4 chk(evt_out == 4'hF, "R6 release merge", evt_out, 4'hF);
    tick(); evt_in = '0; tick();
    // R7 priority combinations
    do_halt(); smi = 1; irq = 1; irq_en = 1; tick();
    #1 chk(wake_cause == 3'd3, "R7 smi over irq", wake_cause, 3); do_ack();
    do_halt(); init = 1; bus_init = 1; smi = 1; nmi = 1; dbg_exc = 1; irq = 1; irq_en = 1; tick();
    #1 chk(wake_cause == 3'd1, "R7 init highest", wake_cause, 1); do_ack();
    do_halt(); bus_init = 1; dbg_exc = 1; tick();
    #1 chk(wake_cause == 3'd2, "R7 bus_init", wake_cause, 2); do_ack();
    do_halt(); dbg_exc = 1; irq = 1; irq_en = 1; tick();
    #1 chk(wake_cause == 3'd5, "R7 debug", wake_cause, 5); do_ack();
    do_halt(); irq = 1; irq_en = 1; tick();
    #1 chk(wake_cause == 3'd6, "R7 enabled irq", wake_cause, 6); do_ack();
    // R8 asynchronous reset while halted with pending bits
    do_halt(); evt_in = 4'hA; tick(); evt_in = '0;
    #1 rst_n = 0;
    #1 chk(halted == 1'b0 && wake_cause == 0, "R8 async reset", halted, 0);
    tick(); rst_n = 1; tick();
    do_halt(); nmi = 1; tick(); nmi = 0; wake_ack = 1; tick(); wake_ack = 0;
    #4 chk(evt_out == 4'h0, "R8 pending cleared by reset", evt_out, 0);
    tick(2);
    // Random phase
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      halt_req = (r < 30);
      irq = ($urandom_range(0, 9) == 0); irq_en = $urandom_range(0, 1);
      nmi = ($urandom_range(0, 29) == 0); smi = ($urandom_range(0, 29) == 0);
      dbg_exc = ($urandom_range(0, 29) == 0); bus_init = ($urandom_range(0, 39) == 0);
      init = ($urandom_range(0, 39) == 0);
      evt_in = NEVT'($urandom_range(0, 15)) & {NEVT{($urandom_range(0, 2) == 0)}};
      wake_ack = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 499) == 0) begin
        #1 rst_n = 0; tick(); rst_n = 1;
      end else tick();
    end
    clr(); tick(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule